// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block is a clocked model of a programmable delay line for a single-bit signal. Each clock cycle stands for one quarter of a basic gate delay. The path always passes through a fixed base section of four cycles. After it comes a series chain of bypassable sections whose lengths double from one cycle to 256 cycles. A nine-bit select decides which sections are inserted. The finest two sections give quarter-gate and half-gate resolution. The seven coarse sections give one to sixty-four gate delays.

A final four-cycle section can also be inserted by a separate select. It is meant for the top of a cascaded range, where it lifts the delay one gate above the all-ones setting so that the total delay keeps rising across the boundary. The input enable gates the serial input before the chain, so a disabled input feeds zeros into the chain. The select lines are taken as already held steady by an external latch.

Top module: `bw_delay_line`

## Requirements
- R1: A synchronous active-high reset clears every section register. On the first cycle after reset the output is 0, and it stays 0 until a 1 that entered after reset has crossed the whole path.
- R2: Once the select and the extra-section select have been held steady for at least D cycles, `dout` equals (`din` AND `en`) delayed by exactly D = 4 + `sel` + 4·`ext_sel` clock cycles. Here `sel` is read as an unsigned binary number.
- R3: With `sel` = 0 and `ext_sel` = 0, the delay is the fixed minimum of 4 cycles.
- R4: Select bit i, where bit 0 is the least significant bit of `sel`, inserts a section of 2^i cycles. Bit 0 adds 1 cycle and bit 1 adds 2 cycles. Bits 2 to 8 add 4, 8, 16, 32, 64, 128 and 256 cycles, which are 1 to 64 gate delays.
- R5: With all nine select bits high and `ext_sel` low, the delay is 515 cycles, which is 511 quarter-gate units above the minimum.
- R6: `ext_sel` high inserts one extra section of 4 cycles, whatever `sel` is. With `sel` all ones this gives 519 cycles.
- R7: The delay is monotonic. It rises strictly from `sel` = 510 to 511, and from 511 to 511 with `ext_sel` high.
- R8: While `en` is low, `din` does not enter the chain. Once `en` has been low for at least D cycles, `dout` stays 0 whatever `din` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one cycle is a quarter gate delay |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial signal to delay |
| en | input | 1 | Input enable; low blocks `din` |
| sel | input | 9 | Section select; bit i inserts 2^i cycles |
| ext_sel | input | 1 | Inserts the extra four-cycle cascade section |
| dout | output | 1 | Delayed signal |

## Verification
Random bit streams run through the path at several select settings. These are the minimum, each single bit alone, two alternating bit patterns, all ones, and the extra section on and off. A wrong section length or a swapped select bit shows up as a mismatch against the input shifted by the expected amount. Streams with a toggling enable separate gating before the chain from gating at the output. A stream with the enable held low shows that input activity is shut out completely. Single-pulse measurements near the top of the range give exact delay counts, which show that the top settings keep rising.

// File: rtl/bw_delay_line.sv
module bw_delay_line #(
  parameter int SEL_W    = 9,
  parameter int BASE_LEN = 4,
  parameter int EXT_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_sel,
  output logic             dout
);
  localparam int DMAX  = BASE_LEN + (1 << SEL_W) - 1 + EXT_LEN;
  localparam int AGE_W = $clog2(DMAX + 2);

  logic                x;
  logic [BASE_LEN-1:0] base_sr;
  logic [EXT_LEN-1:0]  ext_sr;
  logic                node [0:SEL_W];

  assign x = din & en;

  always_ff @(posedge clk) begin
    if (rst) base_sr <= '0;
    else begin
      base_sr[0] <= x;
      for (int k = 1; k < BASE_LEN; k++) base_sr[k] <= base_sr[k-1];
    end
  end

  assign node[0] = base_sr[BASE_LEN-1];

  for (genvar i = 0; i < SEL_W; i++) begin : g_stage
    localparam int LEN = 1 << i;
    logic [LEN-1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else begin
        sr[0] <= node[i];
        for (int k = 1; k < LEN; k++) sr[k] <= sr[k-1];
      end
    end
    assign node[i+1] = sel[i] ? sr[LEN-1] : node[i];
  end

  always_ff @(posedge clk) begin
    if (rst) ext_sr <= '0;
    else begin
      ext_sr[0] <= node[SEL_W];
      for (int k = 1; k < EXT_LEN; k++) ext_sr[k] <= ext_sr[k-1];
    end
  end

  assign dout = ext_sel ? ext_sr[EXT_LEN-1] : node[SEL_W];

  // checker state: cycles the configuration has been steady, cycles enable has been low
  logic [SEL_W:0] prev_cfg;
  logic [AGE_W-1:0] cfg_age, low_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cfg <= '0;
      cfg_age  <= '0;
      low_age  <= '0;
    end else begin
      prev_cfg <= {ext_sel, sel};
      if ({ext_sel, sel} != prev_cfg) cfg_age <= '0;
      else if (cfg_age != AGE_W'(DMAX + 1)) cfg_age <= cfg_age + 1'b1;
      if (en) low_age <= '0;
      else if (low_age != AGE_W'(DMAX + 1)) low_age <= low_age + 1'b1;
    end
  end

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dout);

  a_r3_min_delay: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && !ext_sel && cfg_age > AGE_W'(BASE_LEN))
      |-> dout == $past(din & en, 4));

  a_r4_finest_step: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_W'(1) && !ext_sel && cfg_age > AGE_W'(BASE_LEN + 1))
      |-> dout == $past(din & en, 5));

  a_r6_extra_stage: assert property (@(posedge clk) disable iff (rst)
    (sel == '0 && ext_sel && cfg_age > AGE_W'(BASE_LEN + EXT_LEN))
      |-> dout == $past(din & en, 8));

  a_r8_gated_low: assert property (@(posedge clk) disable iff (rst)
    (low_age > AGE_W'(DMAX)) |-> !dout);

endmodule

// File: tb/bw_delay_line_bench.sv
`timescale 1ns/1ps
module bw_delay_line_bench;
  logic clk = 0, rst = 1, din = 0, en = 0, ext_sel = 0;
  logic [8:0] sel = '0;
  logic dout;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bw_delay_line u_bw_delay_line (.clk(clk), .rst(rst), .din(din), .en(en),
                                 .sel(sel), .ext_sel(ext_sel), .dout(dout));

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dly(logic [8:0] s, logic e);
    return 4 + int'(s) + (e ? 4 : 0);
  endfunction

  task automatic t_reset();
    int nz = 0;
    rst = 1; din = 1; en = 1; sel = '0; ext_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int c = 0; c < 4; c++) begin
      if (dout !== 1'b0) nz++;
      @(negedge clk);
    end
    chk("R1 output zero after reset", nz, 0);
    chk("R3 first post-reset one at cycle 4", int'(dout), 1);
  endtask

  // en_mode: 0 always on, 1 random, 2 always off
  task automatic t_stream(string tag, logic [8:0] s, logic e, int en_mode);
    bit h [0:1023];
    int d = dly(s, e);
    int bad = 0;
    sel = s; ext_sel = e;
    for (int c = 0; c < d + 200; c++) begin
      if (c > 0) @(negedge clk);
      if (c >= d && dout !== h[c-d]) bad++;
      din = 1'($urandom);
      en  = (en_mode == 0) ? 1'b1 : (en_mode == 1) ? 1'($urandom) : 1'b0;
      h[c] = din & en;
    end
    @(negedge clk);
    chk(tag, bad, 0);
  endtask

  task automatic t_pulse(logic [8:0] s, logic e, output int meas);
    meas = -1;
    sel = s; ext_sel = e; en = 1; din = 0;
    repeat (530) @(negedge clk);
    din = 1;
    @(negedge clk);
    din = 0;
    for (int c = 1; c < 600; c++) begin
      if (dout === 1'b1) begin meas = c; break; end
      @(negedge clk);
    end
    chk($sformatf("R2 pulse delay sel=%0d ext=%0d", s, e), meas, dly(s, e));
  endtask

  initial begin
    int m0, m1, m2;
    t_reset();
    t_stream("R3 minimum delay stream", 9'd0, 0, 0);
    for (int i = 0; i < 9; i++)
      t_stream($sformatf("R4 single select bit %0d", i), 9'(1 << i), 0, 0);
    t_stream("R2 pattern 0x155", 9'h155, 0, 0);
    t_stream("R2 pattern 0x0AA", 9'h0AA, 0, 0);
    t_stream("R5 all selects high", 9'h1FF, 0, 0);
    t_stream("R6 extra section alone", 9'd0, 1, 0);
    t_stream("R6 extra section with all ones", 9'h1FF, 1, 0);
    t_stream("R8 toggling enable", 9'h0C3, 0, 1);
    t_stream("R8 enable held low", 9'h1FF, 1, 2);
    t_pulse(9'd510, 0, m0);
    t_pulse(9'd511, 0, m1);
    t_pulse(9'd511, 1, m2);
    chk("R7 510 to 511 rises", int'(m1 > m0), 1);
    chk("R7 extra section rises above all ones", int'(m2 > m1), 1);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule